// File: doc/BRIEF.md
# Pixel Bit-Depth Reducer with Spatial Dither

This block takes a stream of 12-bit-per-channel pixels (RGB or YCbCr, three channels packed in one word) and cuts them to 6, 8 or 10 significant bits per channel. The result keeps its 12-bit width, with the discarded low bits forced to zero. The reduction is either a plain truncation or a spatial dither. A dither adds pseudo-random noise to the bits being dropped before it takes the floor, so that banding is spread into fine noise.

The noise for each channel comes from its own 28-bit linear feedback shift register (LFSR). Each register starts from a programmable seed. The registers reload at every frame start. When frame-random mode is on, the reload value is the seed XORed with a rotated frame count, so successive frames get different patterns. Pixels arrive on a valid/ready stream with frame-start and line-start markers. The configuration inputs are sampled only at a frame start. One register stage holds the result, and it stalls cleanly under output back-pressure.

Top module: `pixel_depth_reducer`

## Requirements
- R1: With truncation and dither both disabled, every pixel leaves unchanged. Each accepted pixel shows up on `out_valid` on the clock after it is accepted. After reset `out_valid` is low and `in_ready` is high.
- R2: With only truncation enabled, truncate depth 0 keeps the top 6 bits and depth 1 keeps the top 8 bits of every channel, clearing the rest (floor, no rounding).
- R3: With dither enabled, the dither depth sets the kept bits: code 0 keeps 6, code 1 keeps 8, and codes 2 and 3 keep 10. With d dropped bits and r the low d bits of the channel's noise word, the output is min((x + r) >> d, 2^(12-d) - 1) << d. It saturates at the largest code and never wraps. Dither takes priority over truncation.
- R4: Each noise register steps once per accepted pixel by state' = {state[26:0], state[27] ^ state[2]} (polynomial x^28 + x^3 + 1). A pixel uses the register value before that step.
- R5: In `in_pix`, R/Y is in bits 35:24, G/Y in 23:12 and B/Cb in 11:0, and each channel has its own seed input. With `cfg_rgb_rand` set, each channel uses its own register. With it clear, all three channels take their noise from the R register, and all registers still step.
- R6: On a frame-start pixel, each register loads (seed XOR frame term) for that pixel. With frame-random off the frame term is 0, so identical input frames give identical output frames.
- R7: With frame-random on, a 4-bit frame count (0 after reset) supplies the frame term, and it advances once per frame start. For dither depth 0 or 1 the frame term is the count rotated left by 2 within 4 bits, and the count wraps from 15 to 0. For depth 2 or 3 the rotation is 1 and the count wraps from 3 or above to 0. The term is XORed into seed bits 3:0. With frame-random off the count is held at 0.
- R8: A reload value of all zeros is replaced by 1, so a register never holds zero.
- R9: Configuration inputs are captured only with an accepted frame-start pixel. A change in the middle of a frame has no effect until the next frame start.
- R10: `in_ready` is high when the output register is empty or being read. While `out_valid` is high and `out_ready` low, the output holds steady. No pixel is lost or duplicated.
- R11: `cfg_hp_rand` selects the unfiltered noise source, so output pixels are identical whether it is set or clear.
- R12: `out_sof` and `out_sol` travel with the pixel they arrived with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_sof | input | 1 | Pixel is the first of a frame |
| in_sol | input | 1 | Pixel is the first of a line |
| in_pix | input | 36 | Three 12-bit channels, R/Y on top |
| cfg_trunc_en | input | 1 | Enable truncation |
| cfg_trunc_depth | input | 1 | 0: 6 bits kept, 1: 8 bits kept |
| cfg_dith_en | input | 1 | Enable spatial dither |
| cfg_dith_depth | input | 2 | 0: 6, 1: 8, 2/3: 10 bits kept |
| cfg_rgb_rand | input | 1 | Independent noise per channel |
| cfg_frame_rand | input | 1 | Vary the reload value per frame |
| cfg_hp_rand | input | 1 | High-pass noise select (raw source) |
| cfg_seed_r | input | 28 | Seed for the R/Y noise register |
| cfg_seed_g | input | 28 | Seed for the G/Y noise register |
| cfg_seed_b | input | 28 | Seed for the B/Cb noise register |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the pixel |
| out_sof | output | 1 | Frame-start marker of the output pixel |
| out_sol | output | 1 | Line-start marker of the output pixel |
| out_pix | output | 36 | Reduced pixel, same packing as input |

## Verification
The assertions assume the upstream source follows the valid/ready rule and holds `in_pix` and its markers while stalled. They also assume every frame starts with a pixel marked `in_sof`, because the reload and the configuration capture both happen on that pixel. The stimulus changes its inputs only at falling edges. It keeps a pixel and its markers in place until a handshake completes, and it begins every frame with a frame-start pixel. The only configuration change it makes inside a frame is the deliberate one that checks R9.

// File: rtl/pdr_pkg.sv
package pdr_pkg;

  typedef struct packed {
    logic       trunc_en;
    logic       trunc_depth;
    logic       dith_en;
    logic [1:0] dith_depth;
    logic       rgb_rand;
    logic       frame_rand;
    logic       hp_rand;
  } pdr_cfg_t;

  // Number of significant bits kept per channel for a configuration.
  function automatic int keep_bits(input pdr_cfg_t c, input int full_w);
    if (c.dith_en) begin
      if (c.dith_depth == 2'd0) return 6;
      if (c.dith_depth == 2'd1) return 8;
      return 10;
    end
    if (c.trunc_en) return c.trunc_depth ? 8 : 6;
    return full_w;
  endfunction

endpackage

// File: rtl/pdr_lfsr.sv
module pdr_lfsr #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         load,
  input  logic [W-1:0] reload,
  output logic [W-1:0] noise
);
  logic [W-1:0] st;
  logic [W-1:0] reload_fix;
  logic [W-1:0] cur;

  assign reload_fix = (reload == '0) ? W'(1) : reload;
  assign cur        = load ? reload_fix : st;
  assign noise      = cur;

  // Taps at bit W-1 and bit 2: x^28 + x^3 + 1 for the default width.
  always_ff @(posedge clk) begin
    if (!rst_n)   st <= W'(1);
    else if (adv) st <= {cur[W-2:0], cur[W-1] ^ cur[2]};
  end

  // R8
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st != '0);

endmodule

// File: rtl/pdr_fcount.sv
module pdr_fcount #(
  parameter int FCW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           frand,
  input  logic           short_mode,
  output logic [FCW-1:0] term
);
  logic [FCW-1:0] fc;
  logic [FCW-1:0] lim;
  logic [FCW-1:0] used;
  int unsigned    sw;

  assign lim  = short_mode ? FCW'(3) : {FCW{1'b1}};
  assign sw   = short_mode ? 1 : 2;
  assign used = frand ? fc : '0;
  assign term = FCW'((used << sw) | (used >> (FCW - sw)));

  always_ff @(posedge clk) begin
    if (!rst_n) fc <= '0;
    else if (tick) begin
      if (!frand || fc >= lim) fc <= '0;
      else                     fc <= fc + 1'b1;
    end
  end

  // R7
  frame_cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !frand) |=> (fc == '0));

endmodule

// File: rtl/pdr_quant.sv
module pdr_quant #(
  parameter int CH_W = 12,
  parameter int RW   = 28,
  parameter int DW   = 4
) (
  input  logic [CH_W-1:0] x,
  input  logic [DW-1:0]   drop,
  input  logic [RW-1:0]   rnd,
  input  logic            dith,
  output logic [CH_W-1:0] y
);
  logic [CH_W-1:0] lowmask;
  logic [CH_W-1:0] noise;
  logic [CH_W:0]   sum;
  logic            unused_hi;

  assign lowmask   = ({{(CH_W-1){1'b0}}, 1'b1} << drop) - 1'b1;
  assign noise     = dith ? (rnd[CH_W-1:0] & lowmask) : '0;
  assign unused_hi = ^rnd[RW-1:CH_W];
  assign sum       = {1'b0, x} + {1'b0, noise};

  // Overflow past full scale saturates at the largest kept code.
  always_comb begin
    if (sum[CH_W]) y = ~lowmask;
    else           y = sum[CH_W-1:0] & ~lowmask;
  end

endmodule

// File: rtl/pixel_depth_reducer.sv
module pixel_depth_reducer #(
  parameter int CH_W   = 12,
  parameter int LFSR_W = 28,
  parameter int FC_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_sof,
  input  logic                in_sol,
  input  logic [3*CH_W-1:0]   in_pix,
  input  logic                cfg_trunc_en,
  input  logic                cfg_trunc_depth,
  input  logic                cfg_dith_en,
  input  logic [1:0]          cfg_dith_depth,
  input  logic                cfg_rgb_rand,
  input  logic                cfg_frame_rand,
  input  logic                cfg_hp_rand,
  input  logic [LFSR_W-1:0]   cfg_seed_r,
  input  logic [LFSR_W-1:0]   cfg_seed_g,
  input  logic [LFSR_W-1:0]   cfg_seed_b,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                out_sof,
  output logic                out_sol,
  output logic [3*CH_W-1:0]   out_pix
);
  import pdr_pkg::*;

  localparam int NCH   = 3;
  localparam int PIX_W = NCH * CH_W;
  localparam int DW    = $clog2(CH_W + 1);

  pdr_cfg_t          cfg_in, cfg_act, cfg_eff;
  logic              acc, frame_go;
  logic [DW-1:0]     drop;
  logic [FC_W-1:0]   fterm;
  logic [LFSR_W-1:0] seed_arr [NCH];
  logic [LFSR_W-1:0] noise    [NCH];
  logic [PIX_W-1:0]  red_pix;
  logic              unused_cfg;

  assign cfg_in = '{trunc_en: cfg_trunc_en, trunc_depth: cfg_trunc_depth,
                    dith_en: cfg_dith_en, dith_depth: cfg_dith_depth,
                    rgb_rand: cfg_rgb_rand, frame_rand: cfg_frame_rand,
                    hp_rand: cfg_hp_rand};

  assign in_ready = !out_valid || out_ready;
  assign acc      = in_valid && in_ready;
  assign frame_go = acc && in_sof;
  assign cfg_eff  = in_sof ? cfg_in : cfg_act;
  assign drop     = DW'(CH_W - keep_bits(cfg_eff, CH_W));
  // High-pass mode reads the raw register output, same path as normal mode.
  assign unused_cfg = cfg_eff.hp_rand;

  assign seed_arr[0] = cfg_seed_r;
  assign seed_arr[1] = cfg_seed_g;
  assign seed_arr[2] = cfg_seed_b;

  always_ff @(posedge clk) begin
    if (!rst_n)        cfg_act <= '0;
    else if (frame_go) cfg_act <= cfg_in;
  end

  pdr_fcount #(.FCW(FC_W)) u_fcount (
    .clk(clk), .rst_n(rst_n), .tick(frame_go),
    .frand(cfg_eff.frame_rand), .short_mode(cfg_eff.dith_depth[1]),
    .term(fterm)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [LFSR_W-1:0] src;

    pdr_lfsr #(.W(LFSR_W)) u_lfsr (
      .clk(clk), .rst_n(rst_n), .adv(acc), .load(frame_go),
      .reload(seed_arr[c] ^ LFSR_W'(fterm)), .noise(noise[c])
    );

    assign src = cfg_eff.rgb_rand ? noise[c] : noise[0];

    pdr_quant #(.CH_W(CH_W), .RW(LFSR_W), .DW(DW)) u_quant (
      .x(in_pix[(NCH-1-c)*CH_W +: CH_W]), .drop(drop), .rnd(src),
      .dith(cfg_eff.dith_en), .y(red_pix[(NCH-1-c)*CH_W +: CH_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_sol   <= 1'b0;
      out_pix   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sof <= in_sof;
        out_sol <= in_sol;
        out_pix <= red_pix;
      end
    end
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix) &&
                                   $stable(out_sof) && $stable(out_sol)));

  // R1
  accept_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_go |=> $stable(cfg_act));

endmodule

// File: tb/pixel_depth_reducer_test.sv
module pixel_depth_reducer_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_sol = 1'b0;
  logic [35:0] in_pix = '0;
  logic in_ready;
  logic tr_en = 0, tr_dp = 0, di_en = 0, rgb = 0, frnd = 0, hp = 0;
  logic [1:0] di_dp = 0;
  logic [27:0] sd_r = 28'h5A3CF17, sd_g = 28'hB01D2E5, sd_b = 28'h3C0FFEE;
  logic out_valid, out_ready, out_sof, out_sol;
  logic [35:0] out_pix;

  int n_tests = 0, n_fail = 0;
  bit stall_en = 0, done = 0;
  string cur_tag = "R1";
  logic [37:0] exp_q[$];
  string tag_q[$];

  // bench-side model state
  logic [27:0] m_st [3];
  int m_fc = 0;
  bit m_tr, m_tdp, m_di, m_rgb, m_fr;
  int m_ddp;

  always #(CLK_P/2) clk = ~clk;

  pixel_depth_reducer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_sol(in_sol), .in_pix(in_pix),
    .cfg_trunc_en(tr_en), .cfg_trunc_depth(tr_dp), .cfg_dith_en(di_en),
    .cfg_dith_depth(di_dp), .cfg_rgb_rand(rgb), .cfg_frame_rand(frnd),
    .cfg_hp_rand(hp), .cfg_seed_r(sd_r), .cfg_seed_g(sd_g), .cfg_seed_b(sd_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_sof(out_sof),
    .out_sol(out_sol), .out_pix(out_pix)
  );

  function automatic logic [27:0] m_step(input logic [27:0] s);
    logic fb = s[27] ^ s[2];
    return (s << 1) | 28'(fb);
  endfunction

  task automatic check(input string tag, input logic [63:0] got,
                       input logic [63:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Compute the expected result for one pixel and queue it.
  task automatic model_push(input bit sof, input bit sol, input logic [35:0] p);
    int n, d, v, q, top, rot, sw, lim;
    logic [35:0] y;
    logic [27:0] src;
    if (sof) begin
      m_tr = tr_en; m_tdp = tr_dp; m_di = di_en; m_ddp = di_dp;
      m_rgb = rgb; m_fr = frnd;
      rot = 0;
      if (m_fr) begin
        sw  = (m_ddp >= 2) ? 1 : 2;
        lim = (m_ddp >= 2) ? 3 : 15;
        rot = ((m_fc << sw) | (m_fc >> (4 - sw))) & 15;
        m_fc = (m_fc >= lim) ? 0 : m_fc + 1;
      end else m_fc = 0;
      m_st[0] = sd_r ^ 28'(rot);
      m_st[1] = sd_g ^ 28'(rot);
      m_st[2] = sd_b ^ 28'(rot);
      for (int c = 0; c < 3; c++) if (m_st[c] == 0) m_st[c] = 28'd1;
    end
    if (m_di) n = (m_ddp == 0) ? 6 : (m_ddp == 1) ? 8 : 10;
    else if (m_tr) n = m_tdp ? 8 : 6;
    else n = 12;
    d = 12 - n;
    top = (1 << n) - 1;
    for (int c = 0; c < 3; c++) begin
      src = m_rgb ? m_st[c] : m_st[0];
      v = int'(p[(2-c)*12 +: 12]) + (m_di ? int'(src % (28'd1 << d)) : 0);
      q = v / (1 << d);
      if (q > top) q = top;
      y[(2-c)*12 +: 12] = 12'(q * (1 << d));
    end
    for (int c = 0; c < 3; c++) m_st[c] = m_step(m_st[c]);
    exp_q.push_back({sof, sol, y});
    tag_q.push_back(cur_tag);
  endtask

  task automatic drive(input bit sof, input bit sol, input logic [35:0] p);
    model_push(sof, sol, p);
    @(negedge clk);
    in_valid = 1'b1; in_sof = sof; in_sol = sol; in_pix = p;
    forever begin
      #(CLK_P/2 - 1);
      if (in_ready) begin @(posedge clk); break; end
      @(negedge clk);
    end
  endtask

  function automatic logic [11:0] pval(input int pat, input int ln,
                                       input int k, input int c);
    if (pat == 0) return 12'((ln*613 + k*149 + c*1031 + 7) & 12'hFFF);
    return 12'hFC0 | 12'((k*7 + ln*3 + c*5) & 63);
  endfunction

  task automatic send_frame(input int pat);
    for (int ln = 0; ln < 3; ln++)
      for (int k = 0; k < 8; k++)
        drive(ln == 0 && k == 0, k == 0,
              {pval(pat, ln, k, 0), pval(pat, ln, k, 1), pval(pat, ln, k, 2)});
    @(negedge clk); in_valid = 1'b0;
  endtask

  // Monitor: owns out_ready and compares the design against the queue.
  initial begin
    int sc = 0;
    logic [37:0] e;
    string t;
    out_ready = 1'b1;
    forever begin
      @(negedge clk);
      sc++;
      out_ready = stall_en ? ((sc % 3) != 0) : 1'b1;
      #(CLK_P/2 - 1);
      if (rst_n && out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          n_tests++; n_fail++;
          $display("FAIL R10 unexpected pixel got=%h exp=none", out_pix);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({t, " R12"}, {out_sof, out_sol, out_pix}, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 reset out_valid", 64'(out_valid), 64'd0);
    check("R1 reset in_ready", 64'(in_ready), 64'd1);

    cur_tag = "R1"; send_frame(0);
    cur_tag = "R2"; tr_en = 1; tr_dp = 0; send_frame(0);
    tr_dp = 1; send_frame(0);
    cur_tag = "R3"; di_en = 1; di_dp = 0; rgb = 1; send_frame(0);
    cur_tag = "R6"; send_frame(0); send_frame(0);
    cur_tag = "R3"; di_dp = 1; send_frame(1);
    di_dp = 2; send_frame(1); send_frame(0);
    tr_en = 0; di_dp = 0; send_frame(1);
    cur_tag = "R5"; rgb = 0; send_frame(0);
    cur_tag = "R4"; rgb = 1; send_frame(0);
    cur_tag = "R7"; frnd = 1; di_dp = 0;
    for (int i = 0; i < 17; i++) send_frame(0);
    di_dp = 2;
    for (int i = 0; i < 5; i++) send_frame(0);
    di_dp = 1; send_frame(0);
    cur_tag = "R8"; frnd = 0; sd_r = 0; sd_g = 0; sd_b = 28'h1; send_frame(0);
    frnd = 1; send_frame(0); send_frame(0);
    frnd = 0; sd_r = 28'h1234567; sd_g = 28'h0ABCDEF; sd_b = 28'hFEDCBA9;
    // R9: change configuration in mid-frame; model keeps the latched one
    cur_tag = "R9"; di_dp = 0;
    for (int ln = 0; ln < 2; ln++)
      for (int k = 0; k < 8; k++) begin
        if (ln == 1 && k == 2) begin di_en = 0; tr_en = 1; tr_dp = 1; rgb = 0; end
        drive(ln == 0 && k == 0, k == 0,
              {pval(0, ln, k, 0), pval(0, ln, k, 1), pval(0, ln, k, 2)});
      end
    @(negedge clk); in_valid = 1'b0;
    cur_tag = "R9"; send_frame(0);
    cur_tag = "R11"; di_en = 1; rgb = 1; hp = 1; send_frame(0);
    hp = 0; send_frame(0);
    cur_tag = "R10"; stall_en = 1; send_frame(1); send_frame(0);
    frnd = 1; send_frame(0);
    repeat (200) @(negedge clk);
    stall_en = 0;
    repeat (10) @(negedge clk);
    // R10 every queued pixel came out exactly once
    check("R10 leftover", 64'(exp_q.size()), 64'd0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule